// File: doc/BRIEF.md
# Programmable Noise Waveform Generator

This block makes the pseudo-random one-bit noise waveform of a sound channel. It keeps a 15-bit shift register with feedback and a signed period timer. On every clock the timer is reduced by the number of elapsed machine cycles given at the `cycles_i` input. When the timer reaches zero or goes below, the register advances one step, the output is updated and one period is added back to the timer. The period is a base value chosen from an eight-entry table, shifted left by a programmable amount.

A configuration byte selects the base value, the shift amount and a short-sequence mode. A trigger strobe starts the channel. It reloads the timer and puts a fixed non-zero seed into the register. While the channel is running and the external enable is high, each step drives the 4-bit output to the current volume when the feedback bit is one, and to zero when it is zero.

Top module: `noise_lfsr_gen`

## Requirements
- R1: While reset is high, and after reset until the first trigger, `wave_o` reads 0.
- R2: The period is base << shift. The base for code 0..7 is 8, 16, 32, 48, 64, 80, 96, 112. The shift is 0..15.
- R3: Configuration byte fields: bits 2:0 hold the base code, bit 3 holds short mode and bits 7:4 hold the shift. A write is stored at the clock edge. It takes effect at the next trigger or reload that follows that edge.
- R4: A trigger sets the channel running, loads the timer with the current period and seeds the register with 0x7FF1. No step happens in that cycle.
- R5: On a step the feedback bit is bit 0 XOR bit 1. The register shifts right by one and the feedback bit enters bit 14.
- R6: In short mode the feedback bit is also written into bit 6. All other bits follow the plain shift.
- R7: Each clock the timer is reduced by `cycles_i`. A step happens when the result is zero or less. The period is then added to that result, so any overshoot carries into the next period.
- R8: While the channel is running and `en_i` is high, each step sets `wave_o` to `vol_i` if the feedback bit is 1 and to 0 if it is 0.
- R9: In any cycle where the channel is not running or `en_i` is low, `wave_o` becomes 0 on the next edge and the register does not advance. The timer keeps counting.
- R10: Between steps `wave_o` holds its value even when `vol_i` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cycles_i | input | CYC_W | Machine cycles elapsed in this clock |
| cfg_wr_i | input | 1 | Strobe that stores the configuration byte |
| cfg_data_i | input | 8 | Configuration byte (code, short mode, shift) |
| trig_i | input | 1 | Start strobe: reload timer, seed register |
| en_i | input | 1 | External channel enable level |
| vol_i | input | VOL_W | Current volume |
| wave_o | output | VOL_W | Noise output level |

## Verification
The generator is driven with several base codes and shifts. Steps every 8 cycles with unit cycle counts separate the table lookup from the shift. A 192-cycle period with cycle counts that vary from one clock to the next, and a period smaller than the cycle count, show whether the overshoot is carried over rather than dropped. Long mode and short mode are each run long enough to show the difference in bit 6 feedback. A ramping volume shows that the output is sampled only at step time. Toggling the enable shows that the output is forced to zero and that the sequence resumes where it stopped, without skipping.

// File: rtl/noise_pkg.sv
package noise_pkg;

   localparam int unsigned CODE_W    = 3;
   localparam int unsigned SHIFT_W   = 4;
   localparam int unsigned BASE_W    = 7;
   localparam int unsigned LFSR_W    = 15;
   localparam int unsigned SHORT_TAP = 6;
   localparam logic [LFSR_W-1:0] LFSR_SEED = 15'h7FF1;

   // Packed MSB first: shift in [7:4], short mode in [3], code in [2:0]
   typedef struct packed {
      logic [SHIFT_W-1:0] shift;
      logic               short_mode;
      logic [CODE_W-1:0]  code;
   } noise_cfg_t;

   // Base period for a code: 8 for code 0, otherwise 16 times the code
   function automatic logic [BASE_W-1:0] base_period(input int unsigned idx);
      int unsigned v;
      v = (idx == 0) ? 8 : 16 * idx;
      return BASE_W'(v);
   endfunction

endpackage

// File: rtl/noise_period_calc.sv
module noise_period_calc
   import noise_pkg::*;
#(
   parameter int unsigned PER_W = 22
) (
   input  logic [CODE_W-1:0]  code_i,
   input  logic [SHIFT_W-1:0] shift_i,
   output logic [PER_W-1:0]   period_o
);

   localparam int unsigned N_CODES = 2 ** CODE_W;

   if (PER_W < BASE_W + (2 ** SHIFT_W) - 1) begin : g_bad_width
      $error("noise_period_calc: PER_W too small for the largest shifted period");
   end

   logic [BASE_W-1:0] base_tab [N_CODES];

   for (genvar g = 0; g < N_CODES; g++) begin : g_tab
      assign base_tab[g] = base_period(g);
   end

   assign period_o = PER_W'(base_tab[code_i]) << shift_i;

endmodule

// File: rtl/noise_step_timer.sv
module noise_step_timer #(
   parameter int unsigned CYC_W = 8,
   parameter int unsigned PER_W = 22,
   parameter int unsigned TW    = 24
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 load_i,
   input  logic [PER_W-1:0]     period_i,
   input  logic [CYC_W-1:0]     cycles_i,
   output logic                 expire_o,
   output logic signed [TW-1:0] timer_o
);

   if (TW < PER_W + 2 || TW < CYC_W + 2) begin : g_bad_tw
      $error("noise_step_timer: TW must exceed both PER_W and CYC_W by two");
   end

   logic signed [TW-1:0] timer_q;
   logic signed [TW-1:0] diff;
   logic signed [TW-1:0] per_s;

   always_comb begin
      diff  = timer_q - $signed(TW'(cycles_i));
      per_s = $signed(TW'(period_i));
   end

   assign expire_o = !load_i && (diff[TW-1] || (diff == '0));
   assign timer_o  = timer_q;

   always_ff @(posedge clk) begin
      if (rst)           timer_q <= '0;
      else if (load_i)   timer_q <= per_s;
      else if (expire_o) timer_q <= diff + per_s;
      else               timer_q <= diff;
   end

   // R4: a load puts the presented period into the timer
   assert_load_R4: assert property (@(posedge clk) disable iff (rst)
      load_i |=> timer_q == $signed(TW'($past(period_i))));

   // R7: after a reload the timer never exceeds the largest period
   assert_ceiling_R7: assert property (@(posedge clk) disable iff (rst)
      timer_q <= $signed(TW'({PER_W{1'b1}})));

   // R7: an expiry adds a positive period back to the reduced count
   assert_carry_R7: assert property (@(posedge clk) disable iff (rst)
      expire_o |=> timer_q > $past(diff));

endmodule

// File: rtl/noise_lfsr_core.sv
module noise_lfsr_core
   import noise_pkg::*;
#(
   parameter int unsigned W   = LFSR_W,
   parameter int unsigned TAP = SHORT_TAP,
   parameter logic [W-1:0] SEED = LFSR_SEED
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         seed_i,
   input  logic         step_i,
   input  logic         short_i,
   output logic         fb_o,
   output logic [W-1:0] state_o
);

   if (W < 3 || TAP >= W - 1) begin : g_bad_geom
      $error("noise_lfsr_core: need W >= 3 and TAP below W-1");
   end

   logic [W-1:0] q;
   logic [W-1:0] nxt;

   assign fb_o = q[0] ^ q[1];

   always_comb begin
      nxt = {fb_o, q[W-1:1]};
      if (short_i) nxt[TAP] = fb_o;
   end

   always_ff @(posedge clk) begin
      if (rst)         q <= '0;
      else if (seed_i) q <= SEED;
      else if (step_i) q <= nxt;
   end

   assign state_o = q;

   // R4: seeding lands the fixed seed
   assert_seed_R4: assert property (@(posedge clk) disable iff (rst)
      seed_i |=> q == SEED);

   // R9: no advance without a step
   assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (!seed_i && !step_i) |=> $stable(q));

   // R5: long-mode step moves every bit down one place
   assert_shift_R5: assert property (@(posedge clk) disable iff (rst)
      (step_i && !seed_i && !short_i) |=> q[W-2:0] == $past(q[W-1:1]));

   // R6: short-mode step puts the same feedback in bit TAP and in the top bit
   assert_short_R6: assert property (@(posedge clk) disable iff (rst)
      (step_i && !seed_i && short_i) |=> q[TAP] == q[W-1]);

endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
   import noise_pkg::*;
#(
   parameter int unsigned CYC_W = 8,
   parameter int unsigned VOL_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CYC_W-1:0] cycles_i,
   input  logic             cfg_wr_i,
   input  logic [7:0]       cfg_data_i,
   input  logic             trig_i,
   input  logic             en_i,
   input  logic [VOL_W-1:0] vol_i,
   output logic [VOL_W-1:0] wave_o
);

   localparam int unsigned PER_W = BASE_W + (2 ** SHIFT_W) - 1;
   localparam int unsigned TW    = ((PER_W > CYC_W) ? PER_W : CYC_W) + 2;

   if ($bits(noise_cfg_t) != 8) begin : g_bad_cfg
      $error("noise_lfsr_gen: configuration record must be one byte");
   end
   if (CYC_W < 1 || VOL_W < 1) begin : g_bad_par
      $error("noise_lfsr_gen: CYC_W and VOL_W must be positive");
   end

   noise_cfg_t           cfg_q;
   logic                 run_q;
   logic                 active;
   logic                 expire;
   logic                 step;
   logic                 fb;
   logic [PER_W-1:0]     period;
   logic signed [TW-1:0] timer;
   logic [LFSR_W-1:0]    lfsr_state;
   logic [VOL_W-1:0]     wave_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q <= '0;
         run_q <= 1'b0;
      end else begin
         if (cfg_wr_i) cfg_q <= noise_cfg_t'(cfg_data_i);
         if (trig_i)   run_q <= 1'b1;
      end
   end

   assign active = run_q & en_i;
   assign step   = expire & active;

   noise_period_calc #(.PER_W(PER_W)) period_i (
      .code_i   (cfg_q.code),
      .shift_i  (cfg_q.shift),
      .period_o (period)
   );

   noise_step_timer #(.CYC_W(CYC_W), .PER_W(PER_W), .TW(TW)) timer_i (
      .clk      (clk),
      .rst      (rst),
      .load_i   (trig_i),
      .period_i (period),
      .cycles_i (cycles_i),
      .expire_o (expire),
      .timer_o  (timer)
   );

   noise_lfsr_core lfsr_i (
      .clk     (clk),
      .rst     (rst),
      .seed_i  (trig_i),
      .step_i  (step),
      .short_i (cfg_q.short_mode),
      .fb_o    (fb),
      .state_o (lfsr_state)
   );

   always_ff @(posedge clk) begin
      if (rst)          wave_q <= '0;
      else if (!active) wave_q <= '0;
      else if (step)    wave_q <= fb ? vol_i : '0;
   end

   assign wave_o = wave_q;

   // R9: an inactive cycle zeroes the output on the next edge
   assert_off_zero_R9: assert property (@(posedge clk) disable iff (rst)
      !active |=> wave_o == '0);

   // R10: the output holds between steps while active
   assert_hold_out_R10: assert property (@(posedge clk) disable iff (rst)
      (active && !step) |=> $stable(wave_o));

   // R8: a step with feedback 0 gives a silent output
   assert_step_low_R8: assert property (@(posedge clk) disable iff (rst)
      (step && !fb) |=> wave_o == '0);

   // R4: a trigger leaves the channel running
   assert_trig_run_R4: assert property (@(posedge clk) disable iff (rst)
      trig_i |=> run_q);

endmodule

// File: tb/noise_lfsr_gen_tb_top.sv
`timescale 1ns/1ps
module noise_lfsr_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] cycles_i = '0;
   logic       cfg_wr_i = 1'b0;
   logic [7:0] cfg_data_i = '0;
   logic       trig_i = 1'b0;
   logic       en_i = 1'b0;
   logic [3:0] vol_i = '0;
   logic [3:0] wave_o;

   always #2 clk = ~clk;

   noise_lfsr_gen dut_i (
      .clk(clk), .rst(rst), .cycles_i(cycles_i), .cfg_wr_i(cfg_wr_i),
      .cfg_data_i(cfg_data_i), .trig_i(trig_i), .en_i(en_i),
      .vol_i(vol_i), .wave_o(wave_o)
   );

   typedef struct {
      logic [3:0] exp;
      string      tag;
   } item_t;

   item_t q[$];
   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 1'b0;

   // reference state, from the requirements
   int          m_timer = 0;
   logic [14:0] m_lfsr  = '0;
   logic [7:0]  m_cfg   = '0;
   bit          m_run   = 1'b0;
   logic [3:0]  m_out   = '0;

   function automatic int ref_period(input logic [7:0] c);
      int b;
      b = (c[2:0] == 3'd0) ? 8 : 16 * int'(c[2:0]);
      return b << c[7:4];
   endfunction

   task automatic drive(input bit wr, input logic [7:0] d, input bit tg,
                        input bit e, input logic [3:0] v, input logic [7:0] c,
                        input string tag);
      item_t it;
      int    diff;
      bit    act;
      logic  fbit;
      @(negedge clk);
      #1;
      rst = 1'b0; cfg_wr_i = wr; cfg_data_i = d; trig_i = tg;
      en_i = e; vol_i = v; cycles_i = c;
      act  = m_run && e;
      diff = m_timer - int'(c);
      if (tg) begin
         m_timer = ref_period(m_cfg);
         m_lfsr  = 15'h7FF1;
         m_run   = 1'b1;
         if (!act) m_out = '0;
      end else if (diff <= 0) begin
         m_timer = diff + ref_period(m_cfg);
         if (act) begin
            fbit   = m_lfsr[0] ^ m_lfsr[1];
            m_lfsr = {fbit, m_lfsr[14:1]};
            if (m_cfg[3]) m_lfsr[6] = fbit;
            m_out  = fbit ? v : 4'd0;
         end else begin
            m_out = '0;
         end
      end else begin
         m_timer = diff;
         if (!act) m_out = '0;
      end
      if (wr) m_cfg = d;
      it.exp = m_out;
      it.tag = tag;
      q.push_back(it);
   endtask

   // monitor: compares each expected item once its edge has passed
   always @(negedge clk) begin
      if (!done && q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         n_checks++;
         if (wave_o !== it.exp) begin
            n_fail++;
            $display("FAIL %s: wave_o=%0h expected %0h", it.tag, wave_o, it.exp);
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      n_checks++;
      if (wave_o !== 4'd0) begin
         n_fail++;
         $display("FAIL R1: wave_o=%0h in reset, expected 0", wave_o);
      end
      // R1: running without a trigger stays silent
      for (int i = 0; i < 12; i++) drive(0, 8'h00, 0, 1, 4'hF, 8'(i % 4), "R1");
      // R3 + R4 + R5 + R8: code 0, shift 0, long mode
      drive(1, 8'h00, 0, 1, 4'hA, 1, "R3");
      drive(0, 8'h00, 1, 1, 4'hA, 1, "R4");
      for (int i = 0; i < 60; i++) drive(0, 8'h00, 0, 1, 4'hA, 1, "R5_R8");
      // R2 + R7: period 48<<2, cycle counts varying
      drive(1, 8'h2B, 0, 1, 4'h7, 1, "R3");
      drive(0, 8'h00, 1, 1, 4'h7, 1, "R4");
      for (int i = 0; i < 150; i++) drive(0, 8'h00, 0, 1, 4'h7, 8'((i % 5) + 3), "R7");
      // R6: short mode on code 0
      drive(1, 8'h08, 0, 1, 4'hC, 4, "R3");
      drive(0, 8'h00, 1, 1, 4'hC, 4, "R4");
      for (int i = 0; i < 120; i++) drive(0, 8'h00, 0, 1, 4'hC, 4, "R6");
      // R10: volume ramps every clock, output moves only on steps
      drive(1, 8'h11, 0, 1, 4'h3, 8, "R3");
      drive(0, 8'h00, 1, 1, 4'h3, 8, "R4");
      for (int i = 0; i < 80; i++) drive(0, 8'h00, 0, 1, 4'(i), 8, "R10");
      // R9: enable toggles in blocks of ten
      drive(1, 8'h00, 0, 1, 4'h9, 2, "R3");
      drive(0, 8'h00, 1, 1, 4'h9, 2, "R4");
      for (int i = 0; i < 80; i++) drive(0, 8'h00, 0, ((i / 10) % 2) == 0, 4'h9, 2, "R9");
      // R3: reconfigure while running, new period at next reload
      drive(1, 8'h1A, 0, 1, 4'h5, 3, "R3");
      for (int i = 0; i < 60; i++) drive(0, 8'h00, 0, 1, 4'h5, 3, "R3");
      // R2: largest period, no step in a short window
      drive(1, 8'hF7, 0, 1, 4'hF, 255, "R3");
      drive(0, 8'h00, 1, 1, 4'hF, 255, "R4");
      for (int i = 0; i < 30; i++) drive(0, 8'h00, 0, 1, 4'hF, 255, "R2");
      // R7: cycle count above period, overshoot carried
      drive(1, 8'h00, 0, 1, 4'h6, 20, "R3");
      drive(0, 8'h00, 1, 1, 4'h6, 20, "R4");
      for (int i = 0; i < 15; i++) drive(0, 8'h00, 0, 1, 4'h6, 20, "R7");
      // drain
      repeat (3) @(negedge clk);
      #1;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule